// File: doc/BRIEF.md
# Iterative virtual-address indirect branch target predictor

The block predicts where an indirect branch will go without a table set aside for indirect targets. It treats the branch as a short chain of virtual conditional branches. Each link of the chain has its own virtual address and virtual history. Each link is looked up in a small direction table of two-bit counters and in a small direct-mapped target buffer, both held inside the block. The search visits one link per clock cycle and ends at the first link that hits in the target buffer and is predicted taken. It also ends, with no prediction, on a target-buffer miss or when the iteration limit is reached. A branch that has shown several distinct targets therefore holds one target-buffer entry per target, each under its own virtual address.

The front end presents a request (branch address and global history) through a valid/ready handshake and waits for a one-cycle completion pulse. When the branch resolves, the back end presents the branch address, the history that was used and the actual target on a second valid/ready port. The block then walks the same chain and trains it. The link that holds the actual target is pushed toward taken, and the links before it are pushed toward not taken. If no link holds the target, the target is installed at the first link that misses.

The controller has three states. ST_IDLE accepts work. ST_LOOKUP performs one prediction step per cycle. ST_TRAIN performs one training step per cycle. The transitions are:
- ST_IDLE to ST_LOOKUP on an accepted request.
- ST_IDLE to ST_TRAIN on an accepted update.
- ST_LOOKUP to ST_LOOKUP on a not-taken hit before the limit.
- ST_LOOKUP to ST_IDLE on a miss, a taken hit or the last step.
- ST_TRAIN to ST_TRAIN on a wrong-target hit before the limit.
- ST_TRAIN to ST_IDLE on a miss (install), a correct hit or the last step.

Top module: `vpc_indirect_pred`

## Requirements
- R1: `req_ready` is 1 only in ST_IDLE, and a request is taken on an edge where `req_valid` and `req_ready` are both 1. `upd_ready` is 1 only in ST_IDLE with `req_valid` low, so a request wins over an update.
- R2: Step i (counting from 0) uses the virtual address `pc ^ ((i * HASH_MULT) mod 2^ADDR_W)`. Step 0 therefore uses the real branch address and the real history.
- R3: The direction table index is the low DIR_IDX_W bits of (virtual address XOR zero-extended virtual history). Counters reset to 01, saturate at 0 and 3, and predict taken when bit 1 is set.
- R4: After a step that hits in the target buffer but is predicted not taken, the virtual history shifts left by one with a 0 inserted (1111, then 1110, then 1100).
- R5: A step that hits in the target buffer and is predicted taken ends the search with `pred_hit`=1 and `pred_target` equal to that entry's target.
- R6: A target-buffer miss, or a not-taken hit at step MAX_ITER-1, ends the search with `pred_hit`=0 and `pred_target`=0.
- R7: `pred_done` is a one-cycle pulse. It is first seen high N+1 cycles after the accepting edge, where N is the number of steps visited.
- R8: Training increments the counter of the step whose entry holds the actual target. It decrements the counter of every earlier step, and those steps all hit with a different target.
- R9: If training reaches a step that misses, it writes the actual target there (tag = virtual address bits above BTB_IDX_W) and increments that step's counter. If all MAX_ITER steps hit with wrong targets, nothing is installed.
- R10: After reset the target buffer is empty, so every request ends after one step with no prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Prediction request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_pc | input | ADDR_W | Indirect branch address |
| req_hist | input | HIST_W | Global history at fetch |
| upd_valid | input | 1 | Resolution update present |
| upd_ready | output | 1 | Update can be taken |
| upd_pc | input | ADDR_W | Resolved branch address |
| upd_hist | input | HIST_W | History used for that branch |
| upd_target | input | TGT_W | Actual target |
| pred_done | output | 1 | One-cycle pulse: search finished |
| pred_hit | output | 1 | A target was predicted |
| pred_target | output | TGT_W | Predicted target (0 when no hit) |

## Verification
The bench keeps a reference model of both tables and compares every search against it. Directed sequences come first:
- A cold lookup separates the empty-buffer case.
- A second target learned by one branch separates a first-step hit from a second-step hit.
- A changed history moves the counter index while the buffer entry stays put.
- Five distinct targets on one branch exercise the iteration limit and the no-install rule.

A sweep then trains several branches with rotating targets and queries each one with both its own and a perturbed history. Each search is checked for hit, target and latency, and the latency also pins down how many steps were visited.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_TRAIN  = 2'd2
    } vpc_state_e;
endpackage

// File: rtl/vpc_dir_table.sv
module vpc_dir_table #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic [1:0]       ctr,
    input  logic             upd_en,
    input  logic             upd_up
);
    localparam int DEPTH = 1 << IDX_W;

    logic [1:0] ctr_q [DEPTH];

    assign ctr = ctr_q[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) ctr_q[k] <= 2'b01;
        end else if (upd_en) begin
            if (upd_up && ctr_q[idx] != 2'b11)
                ctr_q[idx] <= ctr_q[idx] + 2'b01;
            else if (!upd_up && ctr_q[idx] != 2'b00)
                ctr_q[idx] <= ctr_q[idx] - 2'b01;
        end
    end

    // R3
    ctr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_up && ctr == 2'b11) |=> ctr_q[$past(idx)] == 2'b11);

    // R3
    ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_up && ctr == 2'b00) |=> ctr_q[$past(idx)] == 2'b00);
endmodule

// File: rtl/vpc_tgt_table.sv
module vpc_tgt_table #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 4,
    parameter int TGT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] vaddr,
    output logic              hit,
    output logic [TGT_W-1:0]  tgt,
    input  logic              wr_en,
    input  logic [TGT_W-1:0]  wr_tgt
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [TGT_W-1:0] dat_q [DEPTH];

    logic [IDX_W-1:0] slot;
    logic [TAG_W-1:0] tag;

    assign slot = vaddr[IDX_W-1:0];
    assign tag  = vaddr[ADDR_W-1:IDX_W];
    assign hit  = vld_q[slot] && (tag_q[slot] == tag);
    assign tgt  = dat_q[slot];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                vld_q[k] <= 1'b0;
                tag_q[k] <= '0;
                dat_q[k] <= '0;
            end
        end else if (wr_en) begin
            vld_q[slot] <= 1'b1;
            tag_q[slot] <= tag;
            dat_q[slot] <= wr_tgt;
        end
    end

    // R9
    install_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en ##1 $stable(vaddr) |-> (hit && tgt == $past(wr_tgt)));
endmodule

// File: rtl/vpc_indirect_pred.sv
module vpc_indirect_pred
    import vpc_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          HIST_W    = 4,
    parameter int          TGT_W     = 8,
    parameter int          DIR_IDX_W = 4,
    parameter int          BTB_IDX_W = 4,
    parameter int          MAX_ITER  = 4,
    parameter int unsigned HASH_MULT = 32'h5B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [HIST_W-1:0] req_hist,
    input  logic              upd_valid,
    output logic              upd_ready,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic [TGT_W-1:0]  upd_target,
    output logic              pred_done,
    output logic              pred_hit,
    output logic [TGT_W-1:0]  pred_target
);
    localparam int ITER_W = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;

    vpc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] cur_pc;
    logic [HIST_W-1:0] cur_hist;
    logic [ITER_W-1:0] iter_q;
    logic [TGT_W-1:0]  actual_q;

    logic [31:0]          salt_full;
    logic [ADDR_W-1:0]    vaddr, mix;
    logic [DIR_IDX_W-1:0] dir_idx;
    logic [1:0]           ctr;
    logic                 btb_hit, taken, last, match;
    logic [TGT_W-1:0]     btb_tgt;
    logic                 dir_upd_en, dir_upd_up, btb_wr;
    logic                 stay, finish_pred;

    assign salt_full = 32'(iter_q) * HASH_MULT;
    assign vaddr     = cur_pc ^ salt_full[ADDR_W-1:0];
    assign mix       = vaddr ^ ADDR_W'(cur_hist);
    assign dir_idx   = mix[DIR_IDX_W-1:0];
    assign taken     = ctr[1];
    assign last      = (32'(iter_q) == MAX_ITER - 1);
    assign match     = btb_hit && (btb_tgt == actual_q);

    vpc_dir_table #(.IDX_W(DIR_IDX_W)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (dir_idx),
        .ctr    (ctr),
        .upd_en (dir_upd_en),
        .upd_up (dir_upd_up)
    );

    vpc_tgt_table #(.ADDR_W(ADDR_W), .IDX_W(BTB_IDX_W), .TGT_W(TGT_W)) u_btb (
        .clk    (clk),
        .rst_n  (rst_n),
        .vaddr  (vaddr),
        .hit    (btb_hit),
        .tgt    (btb_tgt),
        .wr_en  (btb_wr),
        .wr_tgt (actual_q)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign upd_ready = (state_q == ST_IDLE) && !req_valid;

    always_comb begin
        state_d    = state_q;
        dir_upd_en = 1'b0;
        dir_upd_up = 1'b0;
        btb_wr     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid)      state_d = ST_LOOKUP;
                else if (upd_valid) state_d = ST_TRAIN;
            end
            ST_LOOKUP: begin
                if (!btb_hit || taken || last) state_d = ST_IDLE;
            end
            ST_TRAIN: begin
                dir_upd_en = 1'b1;
                dir_upd_up = !btb_hit || match;
                btb_wr     = !btb_hit;
                if (!btb_hit || match || last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign stay        = (state_q != ST_IDLE) && (state_d == state_q);
    assign finish_pred = (state_q == ST_LOOKUP) && (state_d == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_pc   <= '0;
            cur_hist <= '0;
            iter_q   <= '0;
            actual_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                cur_pc   <= req_pc;
                cur_hist <= req_hist;
                iter_q   <= '0;
            end else if (state_q == ST_IDLE && upd_valid) begin
                cur_pc   <= upd_pc;
                cur_hist <= upd_hist;
                iter_q   <= '0;
                actual_q <= upd_target;
            end else if (stay) begin
                cur_hist <= cur_hist << 1;
                iter_q   <= iter_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_done   <= 1'b0;
            pred_hit    <= 1'b0;
            pred_target <= '0;
        end else begin
            pred_done   <= finish_pred;
            pred_hit    <= finish_pred && btb_hit && taken;
            pred_target <= (finish_pred && btb_hit && taken) ? btb_tgt : '0;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_done |=> !pred_done);

    // R6
    nohit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_done && !pred_hit) |-> pred_target == '0);

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && $past(state_q) == ST_LOOKUP)
            |-> cur_hist == ($past(cur_hist) << 1));

    // R6
    iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(iter_q) < MAX_ITER);
endmodule

// File: tb/sim_vpc_indirect_pred.sv
module sim_vpc_indirect_pred;
    localparam int AW = 8, HW = 4, TW = 8, DW = 4, BW = 4, MI = 4;
    localparam int unsigned HM = 32'h5B;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, req_valid, req_ready, upd_valid, upd_ready;
    logic [AW-1:0] req_pc, upd_pc;
    logic [HW-1:0] req_hist, upd_hist;
    logic [TW-1:0] upd_target, pred_target;
    logic          pred_done, pred_hit;

    vpc_indirect_pred #(.ADDR_W(AW), .HIST_W(HW), .TGT_W(TW), .DIR_IDX_W(DW),
                        .BTB_IDX_W(BW), .MAX_ITER(MI), .HASH_MULT(HM)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc), .req_hist(req_hist),
        .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc), .upd_hist(upd_hist),
        .upd_target(upd_target),
        .pred_done(pred_done), .pred_hit(pred_hit), .pred_target(pred_target)
    );

    int errors = 0;
    int checks = 0;

    logic [1:0] m_ctr [16];
    logic       m_v   [16];
    logic [3:0] m_tag [16];
    logic [7:0] m_tgt [16];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] va_of(input logic [7:0] pc, input int i);
        logic [31:0] s;
        s = i * HM;
        return pc ^ s[7:0];
    endfunction

    task automatic model_pred(input logic [7:0] pc, input logic [3:0] hist,
                              output logic hit, output logic [7:0] tgt, output int iters);
        hit = 1'b0; tgt = 8'h00; iters = MI;
        for (int i = 0; i < MI; i++) begin
            logic [7:0] va;
            logic [3:0] h;
            logic [3:0] di;
            va = va_of(pc, i);
            h  = hist << i;
            di = va[3:0] ^ h;
            if (!(m_v[va[3:0]] && m_tag[va[3:0]] == va[7:4])) begin
                iters = i + 1;
                return;
            end
            if (m_ctr[di][1]) begin
                hit = 1'b1; tgt = m_tgt[va[3:0]]; iters = i + 1;
                return;
            end
        end
    endtask

    task automatic model_train(input logic [7:0] pc, input logic [3:0] hist, input logic [7:0] t);
        for (int i = 0; i < MI; i++) begin
            logic [7:0] va;
            logic [3:0] h;
            logic [3:0] di;
            va = va_of(pc, i);
            h  = hist << i;
            di = va[3:0] ^ h;
            if (!(m_v[va[3:0]] && m_tag[va[3:0]] == va[7:4])) begin
                m_v[va[3:0]] = 1'b1; m_tag[va[3:0]] = va[7:4]; m_tgt[va[3:0]] = t;
                if (m_ctr[di] != 2'b11) m_ctr[di] = m_ctr[di] + 2'b01;
                return;
            end
            if (m_tgt[va[3:0]] == t) begin
                if (m_ctr[di] != 2'b11) m_ctr[di] = m_ctr[di] + 2'b01;
                return;
            end
            if (m_ctr[di] != 2'b00) m_ctr[di] = m_ctr[di] - 2'b01;
        end
    endtask

    task automatic do_pred(input logic [7:0] pc, input logic [3:0] hist, input string tag);
        logic       ehit;
        logic [7:0] etgt;
        int         eit;
        int         n;
        model_pred(pc, hist, ehit, etgt, eit);
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc; req_hist = hist;
        #1;
        chk("R1", "req_ready idle", int'(req_ready), 1);
        chk("R1", "upd_ready blocked", int'(upd_ready), 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        chk("R1", "req_ready busy", int'(req_ready), 0);
        while (!pred_done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R7", "latency", n, eit + 1);
        chk(tag, "pred_hit", int'(pred_hit), int'(ehit));
        chk(tag, "pred_target", int'(pred_target), int'(etgt));
        @(negedge clk);
        chk("R7", "done pulse width", int'(pred_done), 0);
    endtask

    task automatic do_train(input logic [7:0] pc, input logic [3:0] hist, input logic [7:0] t);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_hist = hist; upd_target = t;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        model_train(pc, hist, t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            m_ctr[k] = 2'b01; m_v[k] = 1'b0; m_tag[k] = 4'h0; m_tgt[k] = 8'h00;
        end
        rst_n = 1'b0; req_valid = 1'b0; upd_valid = 1'b0;
        req_pc = '0; req_hist = '0; upd_pc = '0; upd_hist = '0; upd_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset req_ready", int'(req_ready), 1);
        chk("R10", "reset pred_done", int'(pred_done), 0);
        chk("R10", "reset pred_hit", int'(pred_hit), 0);
        rst_n = 1'b1;

        // R10: cold lookups miss at the first step
        do_pred(8'h13, 4'hF, "R10");
        do_pred(8'hC8, 4'h2, "R10");

        // R9: install on miss, R5: taken hit
        do_train(8'h13, 4'hF, 8'hA1);
        do_pred(8'h13, 4'hF, "R9");
        // R4 / R2: second target lives at step 1 with shifted history
        do_train(8'h13, 4'hF, 8'hB2);
        do_pred(8'h13, 4'hF, "R4");
        do_pred(8'h13, 4'hF, "R2");
        // R3: other history selects other counters
        do_pred(8'h13, 4'h0, "R3");
        // R8: retraining the first target
        do_train(8'h13, 4'hF, 8'hA1);
        do_pred(8'h13, 4'hF, "R8");
        do_train(8'h13, 4'hF, 8'hB2);
        do_pred(8'h13, 4'hF, "R8");

        // R9 / R6: five distinct targets on one branch exceed the limit
        for (int k = 0; k < 5; k++) begin
            do_train(8'h47, 4'h9, 8'hC0 + 8'(k));
            do_pred(8'h47, 4'h9, (k == 4) ? "R9" : "R2");
        end
        do_pred(8'h47, 4'h6, "R6");

        // R5 / R6 sweep
        for (int r = 0; r < 8; r++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] pc;
                logic [3:0] h;
                logic [7:0] t;
                pc = 8'(p * 8'h3D + 5);
                h  = 4'(r * 3 + p);
                t  = 8'h40 + 8'((r % 3) * 16 + p);
                do_train(pc, h, t);
                do_pred(pc, h, "R5");
                do_pred(pc, h ^ 4'h5, "R6");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule